// File: doc/BRIEF.md
# Paged Address Translation Unit

This block turns a 14-bit virtual address from one processor port into a 12-bit physical address. Pages are 64 bytes, so the low 6 bits are the page offset and pass straight through. The upper 8 bits are the virtual page number, which is replaced by a 6-bit physical page number. Recent mappings sit in a small fully associative buffer with four slots. When a lookup misses, the block reads one entry from a directly indexed, single-level page table in memory. That entry's word address is the table base input plus the virtual page number, and each process supplies its own base.

Every translation, whether it hits the buffer or needs a table read, goes through the same rights check. The check compares the request's access kind and privilege mode against the entry's permission field and its kernel-only flag. The result is a one-cycle done pulse carrying a fault code and, when there is no fault, the physical address. Only one request is in flight at a time. The ready output is low while a table read is pending. Software pulses the flush input whenever it changes the table base.

Top module: `addr_xlate_unit`

## Requirements
- R1: A translation with no fault returns a physical address made of the mapped 6-bit physical page number above the unchanged 6-bit page offset.
- R2: On a buffer miss, exactly one memory read is issued, on the cycle after acceptance, at word address table_base + virtual page number. The table word has valid in bit 0, rights in bits 2:1, kernel-only in bit 3 and the physical page number in bits 9:4. req_ready stays low until the result is delivered, and rsp_done pulses on the cycle after mem_rd_valid.
- R3: A table word whose valid bit is 0 gives fault code 01 (page fault) with a physical address of zero. Such a word is never cached, so a repeated request reads memory again.
- R4: Request kind 00 (read) is allowed for rights 00 (read-only) and 01 (read-write). Kind 01 (write) is allowed only for rights 01. Kind 10 (execute) is allowed only for rights 10 (execute-only). Kind 11 is never allowed. A disallowed access gives fault code 10 (protection) with address zero.
- R5: Rights value 11 faults with code 10 for every access kind and in both privilege modes.
- R6: An entry marked kernel-only faults with code 10 for a request with req_user=1. The same entry is usable with req_user=0.
- R7: A request that hits the buffer makes no memory read, and its rsp_done pulses on the cycle after acceptance.
- R8: A valid table word is stored in the buffer even when the access faults on rights. With four slots filled in round-robin order, the fifth distinct page evicts the first one stored and leaves the others in place.
- R9: A flush pulse invalidates every buffer slot in one cycle, so the next request to a previously cached page reads the table again.
- R10: After reset, req_ready is 1, rsp_done is 0, mem_rd_req is 0 and the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all buffer slots |
| table_base | input | 10 | Word address of the current page table |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 14 | Virtual address |
| req_kind | input | 2 | Access kind: 00 read, 01 write, 10 execute |
| req_user | input | 1 | 1 for user mode, 0 for kernel mode |
| rsp_done | output | 1 | One-cycle result pulse |
| rsp_fault | output | 2 | 00 none, 01 page fault, 10 protection fault |
| rsp_paddr | output | 12 | Physical address, zero on fault |
| mem_rd_req | output | 1 | Table read request, one cycle |
| mem_rd_addr | output | 10 | Table word address |
| mem_rd_valid | input | 1 | Table read data present |
| mem_rd_data | input | 16 | Table word |

## Verification
A stale or corrupt buffer slot appears at the ports in one of two ways. A hit returns the wrong physical page in the response one cycle after acceptance. Or a request that should hit makes a memory read and takes four cycles instead of one, so the bench checks latency and read counts on every request. A wrong replacement pointer shows up only after the fifth distinct fill, when the wrong page starts to miss. A flush that fails to clear slots is visible on the first request after it. A walker stuck in its wait state holds req_ready low until the watchdog expires.

// File: rtl/xlate_pkg.sv
package xlate_pkg;

    typedef enum logic [1:0] {
        ACC_READ  = 2'b00,
        ACC_WRITE = 2'b01,
        ACC_EXEC  = 2'b10,
        ACC_BAD   = 2'b11
    } acc_kind_e;

    typedef enum logic [1:0] {
        RGT_RO  = 2'b00,
        RGT_RW  = 2'b01,
        RGT_XO  = 2'b10,
        RGT_RSV = 2'b11
    } rights_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'b00,
        FLT_PAGE = 2'b01,
        FLT_PROT = 2'b10
    } fault_e;

    typedef enum logic [1:0] {
        WK_IDLE  = 2'b00,
        WK_FETCH = 2'b01,
        WK_WAIT  = 2'b10
    } walk_state_e;

    // Table word field positions (decoded by the top module)
    localparam int PTE_VALID_BIT = 0;
    localparam int PTE_RGT_LO    = 1;
    localparam int PTE_KERN_BIT  = 3;
    localparam int PTE_PPN_LO    = 4;

    // Shared rights check used by both the hit path and the walk path
    function automatic fault_e check_access(rights_e rgt, logic kern_only,
                                            logic user, acc_kind_e kind);
        logic ok;
        case (kind)
            ACC_READ:  ok = (rgt == RGT_RO) || (rgt == RGT_RW);
            ACC_WRITE: ok = (rgt == RGT_RW);
            ACC_EXEC:  ok = (rgt == RGT_XO);
            default:   ok = 1'b0;
        endcase
        if (kern_only && user) ok = 1'b0;
        return ok ? FLT_NONE : FLT_PROT;
    endfunction

endpackage

// File: rtl/xlate_tlb.sv
module xlate_tlb
    import xlate_pkg::*;
#(
    parameter int VPN_W   = 8,
    parameter int PPN_W   = 6,
    parameter int ENTRIES = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             lk_hit,
    output rights_e          lk_rgt,
    output logic             lk_kern,
    output logic [PPN_W-1:0] lk_ppn,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  rights_e          fill_rgt,
    input  logic             fill_kern,
    input  logic [PPN_W-1:0] fill_ppn
);

    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(ENTRIES - 1);

    typedef struct packed {
        logic [VPN_W-1:0] tag;
        rights_e          rgt;
        logic             kern;
        logic [PPN_W-1:0] ppn;
    } slot_t;

    slot_t              slots [ENTRIES];
    logic [ENTRIES-1:0] vld;
    logic [ENTRIES-1:0] match;
    logic [IDX_W-1:0]   ptr;

    generate
        for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
            assign match[g] = vld[g] && (slots[g].tag == lk_vpn);
        end
    endgenerate

    always_comb begin
        lk_hit  = |match;
        lk_rgt  = RGT_RO;
        lk_kern = 1'b0;
        lk_ppn  = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                lk_rgt  = slots[i].rgt;
                lk_kern = slots[i].kern;
                lk_ppn  = slots[i].ppn;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            vld <= '0;
            ptr <= '0;
        end else if (flush) begin
            vld <= '0;
        end else if (fill_en) begin
            vld[ptr]        <= 1'b1;
            slots[ptr].tag  <= fill_vpn;
            slots[ptr].rgt  <= fill_rgt;
            slots[ptr].kern <= fill_kern;
            slots[ptr].ppn  <= fill_ppn;
            ptr             <= (ptr == LAST_IDX) ? '0 : ptr + 1'b1;
        end
    end

endmodule

// File: rtl/xlate_walker.sv
module xlate_walker
    import xlate_pkg::*;
#(
    parameter int VPN_W = 8,
    parameter int TA_W  = 10,
    parameter int PTE_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [VPN_W-1:0] start_vpn,
    input  logic [TA_W-1:0]  table_base,
    output logic             busy,
    output logic             mem_rd_req,
    output logic [TA_W-1:0]  mem_rd_addr,
    input  logic             mem_rd_valid,
    input  logic [PTE_W-1:0] mem_rd_data,
    output logic             pte_done,
    output logic [PTE_W-1:0] pte_word
);

    walk_state_e     state;
    logic [TA_W-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= WK_IDLE;
            addr_q <= '0;
        end else begin
            case (state)
                WK_IDLE: if (start) begin
                    addr_q <= table_base + TA_W'(start_vpn);
                    state  <= WK_FETCH;
                end
                WK_FETCH: state <= WK_WAIT;
                WK_WAIT:  if (mem_rd_valid) state <= WK_IDLE;
                default:  state <= WK_IDLE;
            endcase
        end
    end

    assign busy        = (state != WK_IDLE);
    assign mem_rd_req  = (state == WK_FETCH);
    assign mem_rd_addr = addr_q;
    assign pte_done    = (state == WK_WAIT) && mem_rd_valid;
    assign pte_word    = mem_rd_data;

endmodule

// File: rtl/addr_xlate_unit.sv
module addr_xlate_unit
    import xlate_pkg::*;
#(
    parameter int VA_W        = 14,
    parameter int PA_W        = 12,
    parameter int PAGE_BYTES  = 64,
    parameter int TLB_ENTRIES = 4,
    parameter int PTE_W       = 16,
    parameter int TA_W        = 10
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic [TA_W-1:0] table_base,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [1:0]      req_kind,
    input  logic            req_user,
    output logic            rsp_done,
    output logic [1:0]      rsp_fault,
    output logic [PA_W-1:0] rsp_paddr,
    output logic            mem_rd_req,
    output logic [TA_W-1:0] mem_rd_addr,
    input  logic            mem_rd_valid,
    input  logic [PTE_W-1:0] mem_rd_data
);

    localparam int OFF_W = $clog2(PAGE_BYTES);
    localparam int VPN_W = VA_W - OFF_W;
    localparam int PPN_W = PA_W - OFF_W;

    logic             accept, walk_busy, hit_sel;
    logic [VPN_W-1:0] req_vpn, vpn_q;
    logic [OFF_W-1:0] req_off, off_q;
    acc_kind_e        kind_q;
    logic             user_q;

    logic             tlb_hit, tlb_kern;
    rights_e          tlb_rgt;
    logic [PPN_W-1:0] tlb_ppn;

    logic             pte_done;
    logic [PTE_W-1:0] pte_word;
    logic             pte_v, pte_kern;
    rights_e          pte_rgt;
    logic [PPN_W-1:0] pte_ppn;

    // selected operands for the single shared rights check
    rights_e          s_rgt;
    logic             s_kern, s_user, s_valid;
    acc_kind_e        s_kind;
    logic [PPN_W-1:0] s_ppn;
    logic [OFF_W-1:0] s_off;
    fault_e           nxt_fault;
    logic             rsp_fire;

    assign req_ready = !walk_busy;
    assign accept    = req_valid && req_ready;
    assign req_vpn   = req_vaddr[VA_W-1:OFF_W];
    assign req_off   = req_vaddr[OFF_W-1:0];
    assign hit_sel   = accept && tlb_hit;

    assign pte_v    = pte_word[PTE_VALID_BIT];
    assign pte_rgt  = rights_e'(pte_word[PTE_RGT_LO +: 2]);
    assign pte_kern = pte_word[PTE_KERN_BIT];
    assign pte_ppn  = pte_word[PTE_PPN_LO +: PPN_W];

    xlate_tlb #(
        .VPN_W  (VPN_W),
        .PPN_W  (PPN_W),
        .ENTRIES(TLB_ENTRIES)
    ) u_tlb (
        .clk      (clk),
        .rst      (rst),
        .flush    (flush),
        .lk_vpn   (req_vpn),
        .lk_hit   (tlb_hit),
        .lk_rgt   (tlb_rgt),
        .lk_kern  (tlb_kern),
        .lk_ppn   (tlb_ppn),
        .fill_en  (pte_done && pte_v),
        .fill_vpn (vpn_q),
        .fill_rgt (pte_rgt),
        .fill_kern(pte_kern),
        .fill_ppn (pte_ppn)
    );

    xlate_walker #(
        .VPN_W(VPN_W),
        .TA_W (TA_W),
        .PTE_W(PTE_W)
    ) u_walk (
        .clk         (clk),
        .rst         (rst),
        .start       (accept && !tlb_hit),
        .start_vpn   (req_vpn),
        .table_base  (table_base),
        .busy        (walk_busy),
        .mem_rd_req  (mem_rd_req),
        .mem_rd_addr (mem_rd_addr),
        .mem_rd_valid(mem_rd_valid),
        .mem_rd_data (mem_rd_data),
        .pte_done    (pte_done),
        .pte_word    (pte_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            vpn_q  <= '0;
            off_q  <= '0;
            kind_q <= ACC_READ;
            user_q <= 1'b0;
        end else if (accept) begin
            vpn_q  <= req_vpn;
            off_q  <= req_off;
            kind_q <= acc_kind_e'(req_kind);
            user_q <= req_user;
        end
    end

    always_comb begin
        if (hit_sel) begin
            s_valid = 1'b1;
            s_rgt   = tlb_rgt;
            s_kern  = tlb_kern;
            s_ppn   = tlb_ppn;
            s_user  = req_user;
            s_kind  = acc_kind_e'(req_kind);
            s_off   = req_off;
        end else begin
            s_valid = pte_v;
            s_rgt   = pte_rgt;
            s_kern  = pte_kern;
            s_ppn   = pte_ppn;
            s_user  = user_q;
            s_kind  = kind_q;
            s_off   = off_q;
        end
        nxt_fault = s_valid ? check_access(s_rgt, s_kern, s_user, s_kind) : FLT_PAGE;
    end

    assign rsp_fire = hit_sel || pte_done;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_done  <= 1'b0;
            rsp_fault <= FLT_NONE;
            rsp_paddr <= '0;
        end else begin
            rsp_done <= rsp_fire;
            if (rsp_fire) begin
                rsp_fault <= nxt_fault;
                rsp_paddr <= (nxt_fault == FLT_NONE) ? {s_ppn, s_off} : '0;
            end
        end
    end

endmodule

// File: rtl/xlate_chk.sv
module xlate_chk #(
    parameter int VA_W  = 14,
    parameter int PA_W  = 12,
    parameter int OFF_W = 6
) (
    input logic            clk,
    input logic            rst,
    input logic            flush,
    input logic            req_valid,
    input logic            req_ready,
    input logic [VA_W-1:0] req_vaddr,
    input logic            rsp_done,
    input logic [1:0]      rsp_fault,
    input logic [PA_W-1:0] rsp_paddr,
    input logic            mem_rd_req,
    input logic            mem_rd_valid,
    input logic            tlb_hit
);

    logic [OFF_W-1:0] off_seen;

    always_ff @(posedge clk) begin
        if (rst) off_seen <= '0;
        else if (req_valid && req_ready) off_seen <= req_vaddr[OFF_W-1:0];
    end

    a_r1_offset_kept: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_fault == 2'b00) |-> rsp_paddr[OFF_W-1:0] == off_seen);

    a_r2_busy_blocks: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> !req_ready);

    a_r2_read_after_accept: assert property (@(posedge clk) disable iff (rst)
        mem_rd_req |-> $past(req_valid && req_ready));

    a_r2_reply_follows_data: assert property (@(posedge clk) disable iff (rst)
        (!req_ready && !mem_rd_req && mem_rd_valid) |=> rsp_done);

    a_r3_fault_zero_addr: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_fault != 2'b00) |-> rsp_paddr == '0);

    a_r4_code_legal: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> rsp_fault != 2'b11);

    a_r7_hit_no_read: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && tlb_hit) |=> (rsp_done && !mem_rd_req));

    a_r9_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> !tlb_hit);

endmodule

bind addr_xlate_unit xlate_chk #(
    .VA_W (VA_W),
    .PA_W (PA_W),
    .OFF_W(OFF_W)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .flush       (flush),
    .req_valid   (req_valid),
    .req_ready   (req_ready),
    .req_vaddr   (req_vaddr),
    .rsp_done    (rsp_done),
    .rsp_fault   (rsp_fault),
    .rsp_paddr   (rsp_paddr),
    .mem_rd_req  (mem_rd_req),
    .mem_rd_valid(mem_rd_valid),
    .tlb_hit     (tlb_hit)
);

// File: tb/addr_xlate_unit_tb.sv
module addr_xlate_unit_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic [9:0]  table_base = 10'h100;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [13:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_user = 1'b0;
    logic        rsp_done;
    logic [1:0]  rsp_fault;
    logic [11:0] rsp_paddr;
    logic        mem_rd_req;
    logic [9:0]  mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [15:0] mem_rd_data = '0;

    int checks = 0;
    int errors = 0;
    int rd_count = 0;
    logic [9:0] last_addr = '0;
    int cnt = 0;
    logic [15:0] ptmem [1024];

    always #5 clk = ~clk;

    addr_xlate_unit u_dut (
        .clk(clk), .rst(rst), .flush(flush), .table_base(table_base),
        .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_user(req_user), .rsp_done(rsp_done),
        .rsp_fault(rsp_fault), .rsp_paddr(rsp_paddr), .mem_rd_req(mem_rd_req),
        .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid),
        .mem_rd_data(mem_rd_data)
    );

    // Memory model: data returned two falling edges after the request is seen
    always @(negedge clk) begin
        mem_rd_valid <= 1'b0;
        if (cnt == 1) begin
            mem_rd_valid <= 1'b1;
            mem_rd_data  <= ptmem[last_addr];
        end
        if (cnt > 0) cnt <= cnt - 1;
        if (mem_rd_req) begin
            cnt       <= 2;
            last_addr <= mem_rd_addr;
            rd_count  <= rd_count + 1;
        end
    end

    task automatic check(input bit ok, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    task automatic xlate(input logic [13:0] va, input logic [1:0] kind, input logic usr,
                         output int lat, output bit rdy_seen);
        while (!req_ready) @(negedge clk);
        req_vaddr = va; req_kind = kind; req_user = usr; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        rdy_seen = 1'b0;
        while (!rsp_done && lat < 50) begin
            if (req_ready) rdy_seen = 1'b1;
            @(negedge clk);
            lat++;
        end
    endtask

    // {vaddr14, kind2, user1, fault2, paddr12, hit1}
    localparam logic [31:0] VEC [14] = '{
        {14'h06A, 2'd0, 1'b1, 2'd0, 12'h16A, 1'b0}, // R1 R2 miss, read RW
        {14'h055, 2'd1, 1'b1, 2'd0, 12'h155, 1'b1}, // R7 hit, write RW
        {14'h0BF, 2'd0, 1'b1, 2'd0, 12'h2BF, 1'b0}, // R4 read RO
        {14'h080, 2'd1, 1'b1, 2'd2, 12'h000, 1'b1}, // R4 write RO faults
        {14'h0C7, 2'd2, 1'b1, 2'd0, 12'h447, 1'b0}, // R4 exec XO
        {14'h0C7, 2'd0, 1'b1, 2'd2, 12'h000, 1'b1}, // R4 read XO faults
        {14'h101, 2'd0, 1'b1, 2'd2, 12'h000, 1'b0}, // R6 user on kernel page
        {14'h101, 2'd1, 1'b0, 2'd0, 12'hFC1, 1'b1}, // R6 kernel, R8 cached on fault
        {14'h140, 2'd0, 1'b0, 2'd2, 12'h000, 1'b0}, // R5 reserved, evicts page 1
        {14'h040, 2'd0, 1'b1, 2'd0, 12'h140, 1'b0}, // R8 page 1 evicted
        {14'h0C0, 2'd2, 1'b1, 2'd0, 12'h440, 1'b1}, // R8 page 3 kept
        {14'h180, 2'd0, 1'b1, 2'd1, 12'h000, 1'b0}, // R3 invalid
        {14'h18C, 2'd0, 1'b0, 2'd1, 12'h000, 1'b0}, // R3 not cached
        {14'h0C0, 2'd3, 1'b1, 2'd2, 12'h000, 1'b1}  // R4 kind 11
    };

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        int lat;
        bit rdy_seen;
        int rd0;
        for (int i = 0; i < 1024; i++) ptmem[i] = '0;
        // word: [9:4] ppn, [3] kernel-only, [2:1] rights, [0] valid
        ptmem[10'h101] = 16'h0053; // ppn 05 RW
        ptmem[10'h102] = 16'h00A1; // ppn 0A RO
        ptmem[10'h103] = 16'h0115; // ppn 11 XO
        ptmem[10'h104] = 16'h03FB; // ppn 3F RW kernel
        ptmem[10'h105] = 16'h0017; // ppn 01 reserved
        ptmem[10'h106] = 16'h0070; // invalid
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R10 reset state
        check(req_ready == 1'b1, "R10 req_ready after reset", req_ready, 1);
        check(rsp_done == 1'b0, "R10 rsp_done after reset", rsp_done, 0);
        check(mem_rd_req == 1'b0, "R10 mem_rd_req after reset", mem_rd_req, 0);

        for (int v = 0; v < 14; v++) begin
            logic [31:0] e;
            e = VEC[v];
            rd0 = rd_count;
            xlate(e[31:18], e[17:16], e[15], lat, rdy_seen);
            check(rsp_fault == e[14:13], $sformatf("R3 R4 R5 R6 fault, vector %0d", v),
                  rsp_fault, e[14:13]);
            check(rsp_paddr == e[12:1], $sformatf("R1 paddr, vector %0d", v),
                  rsp_paddr, e[12:1]);
            if (e[0]) begin
                check(lat == 1, $sformatf("R7 hit latency, vector %0d", v), lat, 1);
                check(rd_count == rd0, $sformatf("R7 no read on hit, vector %0d", v),
                      rd_count - rd0, 0);
            end else begin
                check(lat == 4, $sformatf("R2 walk latency, vector %0d", v), lat, 4);
                check(rd_count == rd0 + 1, $sformatf("R2 one read, vector %0d", v),
                      rd_count - rd0, 1);
                check(last_addr == 10'h100 + {2'b00, e[31:24]},
                      $sformatf("R2 table address, vector %0d", v),
                      last_addr, 10'h100 + {2'b00, e[31:24]});
                check(!rdy_seen, $sformatf("R2 ready low while walking, vector %0d", v),
                      rdy_seen, 0);
            end
        end

        // R9: flush, then cached page 3 must walk again
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        rd0 = rd_count;
        xlate(14'h0C5, 2'd2, 1'b1, lat, rdy_seen);
        check(lat == 4, "R9 walk after flush latency", lat, 4);
        check(rd_count == rd0 + 1, "R9 read after flush", rd_count - rd0, 1);
        check(rsp_paddr == 12'h445, "R9 R1 paddr after flush", rsp_paddr, 12'h445);
        // and is cached again afterwards
        xlate(14'h0C0, 2'd2, 1'b1, lat, rdy_seen);
        check(lat == 1, "R9 refilled slot hits", lat, 1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule